// File: doc/BRIEF.md
# Inter-Cluster Wakeup Forwarding Network

This block carries completion tags from the clusters that produce results to the issue queues of the clusters that consume them. In each cycle every cluster may present up to `CW` completing tags, each with its own valid bit. Each source/destination pair of clusters has its own path. A path has a fixed forwarding delay and a fixed per-cycle throughput, taken from two build-time matrices. So a single completing tag can reach different destination queues in different cycles. Zero-latency paths join pseudo-clusters into one forwarding domain. The issue queues behind such paths stay separate, but a producer and its consumer can still issue in consecutive cycles.

Every path has a small collapsing backlog queue. The path takes the held tags first, oldest first, and then the new tags of the cycle in ascending lane order. It sends the first `BW(s,d)` of them and keeps the rest. A path with latency `L > 0` puts the sent tags through `L` register stages. A path with zero latency passes them to the destination in the same cycle. Each path runs a three-state controller:
- IDLE: the backlog is empty.
- BACKLOG: some tags are held, but there is room for a full cycle of new tags.
- CHOKED: the free room is less than `CW`.

The controller moves between these states from the backlog count after each cycle:
- to IDLE when the count is 0;
- to CHOKED when the count is greater than `QD-CW`;
- to BACKLOG otherwise.

A CHOKED path raises the stall of its source cluster. A destination sees its incoming tags as a vector of `NCL*BWM` broadcast slots, where `BWM` is the largest bandwidth entry. Slot `s*BWM+k` is the `k`-th tag that arrives from source `s` in that cycle.

Top module: `wakeup_xnet`

## Requirements
- R1: After reset, every broadcast slot is empty and no stall is raised until tags have been accepted.
- R2: With no backlog and within bandwidth, a tag that cluster s completes in cycle t appears at destination d in cycle t+LAT(s,d), where LAT(s,d) is the 4-bit entry at bits [4*(s*NCL+d)+3 : 4*(s*NCL+d)] of `LAT_MAP`.
- R3: A path with zero latency delivers its tags to the destination combinationally, in the same cycle the tags are presented.
- R4: A cluster sees its own completions in the same cycle, whatever value the diagonal entry of `LAT_MAP` holds.
- R5: No more than BW(s,d) tags leave a path in any cycle. BW(s,d) is the 4-bit entry of `BW_MAP` at the same position as the latency entry, and it must be 1 or more.
- R6: Tags beyond a path's bandwidth are held and sent in later cycles. Held tags go first, oldest first, then the new tags of the cycle in ascending lane order.
- R7: `stall[s]` is high in a cycle exactly when some path from source s holds more than QD-CW tags at the start of that cycle.
- R8: While `stall[s]` is high, the completions that cluster s presents are discarded on every path and never reach any destination.
- R9: Tags from source s arrive in slots s*BWM+0 upward without gaps. A slot s*BWM+k with k >= BW(s,d) is never valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_v | input | NCL*CW | Completion valid, [cluster][lane] |
| cmp_tag | input | NCL*CW*TAG_W | Completion tags, [cluster][lane] |
| bc_v | output | NCL*NCL*BWM | Broadcast valid, [destination][slot] |
| bc_tag | output | NCL*NCL*BWM*TAG_W | Broadcast tags, [destination][slot] |
| stall | output | NCL | Per-source stall; inputs are discarded while high |

## Verification
A corrupted backlog count or a wrong controller state shows at `stall` in the next cycle. A lost, duplicated or reordered held tag shows in a broadcast slot once the path drains, which takes at most QD/BW cycles plus the path latency. A delay stage off by one moves each arrival by one cycle on that single source/destination pair only. The bench compares every slot and every stall in every cycle, so such faults are caught at their first visible cycle.

// File: rtl/wxn_pkg.sv
package wxn_pkg;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_BACKLOG = 2'd1,
        PS_CHOKED  = 2'd2
    } path_state_t;

    // Matrices are passed zero-extended to 256 bits (up to 8x8 clusters).
    function automatic int map_nib(input logic [255:0] m, input int i);
        return int'(m[i*4 +: 4]);
    endfunction

    function automatic int map_max(input logic [255:0] m, input int n);
        int r;
        r = 1;
        for (int i = 0; i < n; i++) begin
            if (int'(m[i*4 +: 4]) > r) r = int'(m[i*4 +: 4]);
        end
        return r;
    endfunction

endpackage

// File: rtl/wxn_delay.sv
module wxn_delay #(
    parameter int W = 9,
    parameter int L = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (L == 0) begin : g_bypass
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign q = d;
        end else begin : g_line
            logic [L-1:0][W-1:0] stage;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < L; i++) stage[i] <= stage[i-1];
                end
            end
            assign q = stage[L-1];
        end
    endgenerate
endmodule

// File: rtl/wxn_pair.sv
module wxn_pair
    import wxn_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CW    = 2,
    parameter int QD    = 4,
    parameter int BW    = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CW-1:0]              in_v,
    input  logic [CW-1:0][TAG_W-1:0]   in_tag,
    output logic [BW-1:0]              out_v,
    output logic [BW-1:0][TAG_W-1:0]   out_tag,
    output logic                       choked
);
    localparam int PL    = QD + CW + BW;
    localparam int PIX_W = $clog2(PL);
    localparam int CNT_W = $clog2(QD + 1);

    path_state_t             state, nstate;
    logic [CNT_W-1:0]        q_cnt, ncnt;
    logic [TAG_W-1:0]        q_tag [QD];
    logic [TAG_W-1:0]        nq    [QD];
    logic [TAG_W-1:0]        pool  [PL];
    logic [PIX_W-1:0]        wp;
    logic [PIX_W-1:0]        keep;

    // Merge held tags (oldest first) with new lanes, send the head, keep the tail.
    always_comb begin
        for (int j = 0; j < PL; j++) pool[j] = '0;
        for (int j = 0; j < QD; j++) begin
            if (j < int'(q_cnt)) pool[j] = q_tag[j];
        end
        wp = PIX_W'(q_cnt);
        for (int k = 0; k < CW; k++) begin
            if (in_v[k]) begin
                pool[wp] = in_tag[k];
                wp = wp + PIX_W'(1);
            end
        end
        for (int b = 0; b < BW; b++) begin
            out_v[b]   = (PIX_W'(b) < wp);
            out_tag[b] = pool[b];
        end
        keep = (wp > PIX_W'(BW)) ? wp - PIX_W'(BW) : '0;
        for (int j = 0; j < QD; j++) nq[j] = pool[j+BW];
        ncnt = CNT_W'(keep);
    end

    always_comb begin
        if (ncnt == '0)                      nstate = PS_IDLE;
        else if (ncnt > CNT_W'(QD - CW))     nstate = PS_CHOKED;
        else                                 nstate = PS_BACKLOG;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_IDLE;
        else     state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_cnt <= '0;
            for (int j = 0; j < QD; j++) q_tag[j] <= '0;
        end else begin
            q_cnt <= ncnt;
            for (int j = 0; j < QD; j++) q_tag[j] <= nq[j];
        end
    end

    always_comb begin
        unique case (state)
            PS_IDLE:    choked = 1'b0;
            PS_BACKLOG: choked = 1'b0;
            PS_CHOKED:  choked = 1'b1;
            default:    choked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wakeup_xnet.sv
module wakeup_xnet
    import wxn_pkg::*;
#(
    parameter int NCL   = 3,
    parameter int CW    = 2,
    parameter int TAG_W = 8,
    parameter int QD    = 4,
    parameter logic [NCL*NCL*4-1:0] LAT_MAP = 36'h032001210,
    parameter logic [NCL*NCL*4-1:0] BW_MAP  = 36'h221121212,
    localparam int BWM   = map_max(256'(BW_MAP), NCL*NCL),
    localparam int SLOTS = NCL * BWM
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [NCL-1:0][CW-1:0]                   cmp_v,
    input  logic [NCL-1:0][CW-1:0][TAG_W-1:0]        cmp_tag,
    output logic [NCL-1:0][SLOTS-1:0]                bc_v,
    output logic [NCL-1:0][SLOTS-1:0][TAG_W-1:0]     bc_tag,
    output logic [NCL-1:0]                           stall
);
    logic [NCL-1:0][NCL-1:0]                   pst;
    logic [NCL-1:0][CW-1:0]                    acc_v;
    logic [NCL-1:0][NCL-1:0][BWM-1:0]          sv;
    logic [NCL-1:0][NCL-1:0][BWM-1:0][TAG_W-1:0] stg;

    genvar gs, gd, gk;
    generate
        for (gs = 0; gs < NCL; gs++) begin : g_src
            assign stall[gs] = |pst[gs];
            assign acc_v[gs] = cmp_v[gs] & ~{CW{stall[gs]}};
            for (gd = 0; gd < NCL; gd++) begin : g_dst
                localparam int P_IDX = gs * NCL + gd;
                localparam int P_LAT = (gs == gd) ? 0 : map_nib(256'(LAT_MAP), P_IDX);
                localparam int P_BW  = map_nib(256'(BW_MAP), P_IDX);
                logic [P_BW-1:0]            ev, dv;
                logic [P_BW-1:0][TAG_W-1:0] et, dt;

                wxn_pair #(.TAG_W(TAG_W), .CW(CW), .QD(QD), .BW(P_BW)) u_pair (
                    .clk     (clk),
                    .rst     (rst),
                    .in_v    (acc_v[gs]),
                    .in_tag  (cmp_tag[gs]),
                    .out_v   (ev),
                    .out_tag (et),
                    .choked  (pst[gs][gd])
                );

                wxn_delay #(.W(P_BW * (TAG_W + 1)), .L(P_LAT)) u_dly (
                    .clk (clk),
                    .rst (rst),
                    .d   ({ev, et}),
                    .q   ({dv, dt})
                );

                for (gk = 0; gk < BWM; gk++) begin : g_slot
                    if (gk < P_BW) begin : g_live
                        assign sv[gd][gs][gk]  = dv[gk];
                        assign stg[gd][gs][gk] = dt[gk];
                    end else begin : g_dead
                        assign sv[gd][gs][gk]  = 1'b0;
                        assign stg[gd][gs][gk] = '0;
                    end
                end
            end
        end
        for (gd = 0; gd < NCL; gd++) begin : g_out
            assign bc_v[gd]   = sv[gd];
            assign bc_tag[gd] = stg[gd];
        end
    endgenerate
endmodule

// File: rtl/wxn_checker.sv
module wxn_checker
    import wxn_pkg::*;
#(
    parameter int NCL = 3,
    parameter int CW  = 2,
    parameter logic [NCL*NCL*4-1:0] BW_MAP = 36'h221121212,
    localparam int BWM   = map_max(256'(BW_MAP), NCL*NCL),
    localparam int SLOTS = NCL * BWM
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NCL-1:0][CW-1:0]     cmp_v,
    input logic [NCL-1:0][SLOTS-1:0]  bc_v,
    input logic [NCL-1:0]             stall
);
    // R1: stall stays low in the first cycle after reset
    a_r1_no_stall_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stall == '0));

    genvar gs, gd, gk;
    generate
        for (gs = 0; gs < NCL; gs++) begin : g_s
            // R7: a stall can only rise after the source offered tags
            a_r7_stall_needs_input: assert property (@(posedge clk) disable iff (rst)
                $rose(stall[gs]) |-> $past(|cmp_v[gs]));

            if (map_nib(256'(BW_MAP), gs * NCL + gs) >= CW) begin : g_diag
                // R4: own completions appear in the same cycle
                a_r4_own_same_cycle: assert property (@(posedge clk) disable iff (rst)
                    !stall[gs] |-> ($countones(bc_v[gs][gs*BWM +: BWM]) == $countones(cmp_v[gs])));
            end

            for (gd = 0; gd < NCL; gd++) begin : g_d
                localparam int P_BW = map_nib(256'(BW_MAP), gs * NCL + gd);
                // R5: per-path arrivals bounded by bandwidth
                a_r5_bw_cap: assert property (@(posedge clk) disable iff (rst)
                    $countones(bc_v[gd][gs*BWM +: BWM]) <= P_BW);
                for (gk = 0; gk < BWM; gk++) begin : g_k
                    if (gk >= P_BW) begin : g_dead
                        // R9: slots above the path bandwidth stay empty
                        a_r9_dead_slot: assert property (@(posedge clk) disable iff (rst)
                            !bc_v[gd][gs*BWM + gk]);
                    end
                end
            end
        end
    endgenerate
endmodule

bind wakeup_xnet wxn_checker #(.NCL(NCL), .CW(CW), .BW_MAP(BW_MAP)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cmp_v (cmp_v),
    .bc_v  (bc_v),
    .stall (stall)
);

// File: tb/wakeup_xnet_tb.sv
module wakeup_xnet_tb;
    localparam int CLK_P = 10;
    localparam int NCL   = 3;
    localparam int CW    = 2;
    localparam int TAG_W = 8;
    localparam int QD    = 4;
    localparam int BWM   = 2;
    localparam int SLOTS = NCL * BWM;
    localparam int NP    = NCL * NCL;
    // Diagonal entry of cluster 1 set to 5 on purpose: it must be ignored (R4).
    localparam logic [NCL*NCL*4-1:0] T_LAT = 36'h032051210;
    localparam logic [NCL*NCL*4-1:0] T_BW  = 36'h221121212;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCL-1:0][CW-1:0]               cmp_v   = '0;
    logic [NCL-1:0][CW-1:0][TAG_W-1:0]    cmp_tag = '0;
    logic [NCL-1:0][SLOTS-1:0]            bc_v;
    logic [NCL-1:0][SLOTS-1:0][TAG_W-1:0] bc_tag;
    logic [NCL-1:0]                       stall;

    always #(CLK_P/2) clk = ~clk;

    wakeup_xnet #(
        .NCL(NCL), .CW(CW), .TAG_W(TAG_W), .QD(QD),
        .LAT_MAP(T_LAT), .BW_MAP(T_BW)
    ) u_dut (
        .clk(clk), .rst(rst), .cmp_v(cmp_v), .cmp_tag(cmp_tag),
        .bc_v(bc_v), .bc_tag(bc_tag), .stall(stall)
    );

    int n_chk = 0;
    int n_err = 0;
    int nt    = 1;
    int t     = 0;
    string phase = "R1 reset idle";

    int mq [NP][QD];
    int mc [NP];
    bit          hv [16][NP][BWM];
    logic [7:0]  ht [16][NP][BWM];

    function automatic int lat_of(input int s, input int d);
        return (s == d) ? 0 : int'(T_LAT[(s*NCL+d)*4 +: 4]);
    endfunction
    function automatic int bw_of(input int s, input int d);
        return int'(T_BW[(s*NCL+d)*4 +: 4]);
    endfunction

    // Called just after a rising edge; returns just after the next one.
    task automatic cyc(input logic [NCL-1:0][CW-1:0] v);
        logic [NCL-1:0][CW-1:0][TAG_W-1:0] tg;
        logic [NCL-1:0] est;
        int pool [QD+CW];
        int nmq [NP][QD];
        int nmc [NP];
        logic [SLOTS-1:0] ev, gv;
        logic [SLOTS-1:0][TAG_W-1:0] et, gt;
        tg = '0;
        for (int s = 0; s < NCL; s++)
            for (int k = 0; k < CW; k++)
                if (v[s][k]) begin tg[s][k] = 8'(nt); nt++; end
        cmp_v = v;
        cmp_tag = tg;
        for (int s = 0; s < NCL; s++) begin
            est[s] = 1'b0;
            for (int d = 0; d < NCL; d++) if (mc[s*NCL+d] > QD - CW) est[s] = 1'b1;
        end
        for (int p = 0; p < NP; p++) begin
            int s, d, tot, bw;
            s = p / NCL; d = p % NCL; tot = 0; bw = bw_of(s, d);
            for (int j = 0; j < mc[p]; j++) begin pool[tot] = mq[p][j]; tot++; end
            if (!est[s])
                for (int k = 0; k < CW; k++)
                    if (v[s][k]) begin pool[tot] = int'(tg[s][k]); tot++; end
            for (int b = 0; b < BWM; b++) begin
                hv[t%16][p][b] = (b < bw) && (b < tot);
                ht[t%16][p][b] = ((b < bw) && (b < tot)) ? 8'(pool[b]) : 8'h0;
            end
            nmc[p] = (tot > bw) ? tot - bw : 0;
            for (int j = 0; j < QD; j++) nmq[p][j] = (j < nmc[p]) ? pool[j+bw] : 0;
        end
        @(negedge clk);
        n_chk++;
        if (stall !== est) begin
            n_err++;
            $display("FAIL %s (R7) t=%0d stall: got %b expected %b", phase, t, stall, est);
        end
        for (int d = 0; d < NCL; d++) begin
            ev = '0; et = '0; gv = '0; gt = '0;
            for (int s = 0; s < NCL; s++) begin
                int l;
                l = lat_of(s, d);
                if (t >= l)
                    for (int b = 0; b < BWM; b++) begin
                        ev[s*BWM+b] = hv[(t-l)%16][s*NCL+d][b];
                        et[s*BWM+b] = ht[(t-l)%16][s*NCL+d][b];
                    end
            end
            for (int i = 0; i < SLOTS; i++) begin
                gv[i] = bc_v[d][i];
                gt[i] = bc_v[d][i] ? bc_tag[d][i] : 8'h0;
            end
            n_chk++;
            if (gv !== ev || gt !== et) begin
                n_err++;
                $display("FAIL %s t=%0d dst%0d: got v=%b tag=%h expected v=%b tag=%h",
                         phase, t, d, gv, gt, ev, et);
            end
        end
        for (int p = 0; p < NP; p++) begin
            mc[p] = nmc[p];
            for (int j = 0; j < QD; j++) mq[p][j] = nmq[p][j];
        end
        t++;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        for (int p = 0; p < NP; p++) begin
            mc[p] = 0;
            for (int j = 0; j < QD; j++) mq[p][j] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        phase = "R1 reset idle";
        repeat (2) cyc('0);

        phase = "R2 R3 R4 single tags";
        for (int s = 0; s < NCL; s++) begin
            logic [NCL-1:0][CW-1:0] v;
            v = '0; v[s][0] = 1'b1;
            cyc(v);
            repeat (5) cyc('0);
        end
        cyc(6'b11_11_11);
        repeat (5) cyc('0);

        phase = "R5 R6 R7 backlog";
        repeat (4) cyc(6'b00_11_00);
        repeat (6) cyc('0);

        phase = "R8 stalled inputs ignored";
        repeat (6) cyc(6'b11_11_11);
        repeat (6) cyc('0);

        phase = "R9 R5 R6 sweep";
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[5:0] & lfsr[11:6]);
        end
        repeat (8) cyc('0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule